// File: doc/BRIEF.md
# Self-Checking 2-to-4 Decoder with Duplicated Parity Cells

This block turns a 2-bit selection into a one-hot 4-bit word and checks its own work while it runs. The decoding is split over three cells: a source cell that expands the low selection bit into a true/complement pair, and two gating cells that each combine that pair with the high selection bit to produce one half of the output word. Every cell exists twice, as copy A and copy B. Each copy forms a parity bit over the data it receives and another over the data it produces. A cell is flagged when the XOR of the two input parities differs from the XOR of the two output parities. That is the case when the input parities agree and the output parities do not, and also when the input parities differ and the output parities agree.

The three per-cell flags pass through an XOR chain that starts from a constant seed of zero. The end of the chain is the error flag. The per-cell flags also leave the block as a vector that points at the failing cell. Copy A of each cell drives the functional path. Copy B exists only for the comparison. Two test-only vectors can flip single output bits of either copy of any cell, so a bench can exercise the detection while the block keeps decoding. The block is purely combinational and has no clock.

Top module: `pcd_decoder`

## Requirements
- R1: With both injection vectors at zero, `y` is one-hot and `y[k]` is 1 exactly when `sel` equals k.
- R2: With both injection vectors at zero, `err_t` is 0 and `fault_cell` is all zeros for every value of `sel`.
- R3: Injection bit 2k+j of `inj_a` or `inj_b` flips output j of copy A or copy B of cell k. Cell 0 output 0 is "sel[0] is 0" and output 1 is `sel[0]`. Cell 1 outputs 0 and 1 are `y[0]` and `y[1]`. Cell 2 outputs 0 and 1 are `y[2]` and `y[3]`. Cells 1 and 2 take the pair from copy A of cell 0.
- R4: A flip in copy B of any cell never changes `y`.
- R5: Any single set bit across `inj_a` and `inj_b`, in cell k, sets `err_t` to 1 and sets only `fault_cell[k]`.
- R6: Cell k is flagged exactly when an odd number of bits is set across its four injection bits. Two flips inside one cell, in one copy or split over both copies, leave that cell unflagged.
- R7: `err_t` is the XOR of the three cell flags over a seed of 0. Faults in two different cells set both `fault_cell` bits and leave `err_t` at 0. Faults in all three cells give `err_t` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 2 | Binary selection to decode |
| inj_a | input | 6 | Test-only flips for copy A outputs, bits 2k+1:2k for cell k |
| inj_b | input | 6 | Test-only flips for copy B outputs, bits 2k+1:2k for cell k |
| y | output | 4 | One-hot decoded word from the copy A path |
| err_t | output | 1 | Error flag from the seeded XOR chain |
| fault_cell | output | 3 | One flag per cell, bit k for cell k |

## Verification
The bench walks every selection against every single-bit flip in both copies of all three cells. A design that compares the wrong copies or fails to reduce parity over all outputs would miss some of these flips or blame the wrong cell. Copy A flips in the source cell are checked to corrupt `y` the way the model predicts. Copy B flips are checked to leave `y` alone, which catches a design that drives the outputs from the wrong copy. Paired flips inside one cell, flips spread over two and three cells, and the zero seed are also covered. A design that used OR instead of XOR in the chain, or that flagged any mismatch instead of an odd parity difference, would report the wrong `err_t` or `fault_cell` there.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned CELL_IN_W  = 3;
  localparam int unsigned CELL_OUT_W = 2;
  localparam int unsigned NCELL      = 3;
  localparam int unsigned INJ_W      = NCELL * CELL_OUT_W;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned Y_W        = 1 << SEL_W;

  typedef enum logic [1:0] {
    CK_SPLIT = 2'd0,
    CK_LOW   = 2'd1,
    CK_HIGH  = 2'd2
  } cell_kind_e;
endpackage

// File: rtl/pcd_copy.sv
module pcd_copy
  import pcd_pkg::*;
#(
  parameter cell_kind_e KIND = CK_SPLIT,
  parameter int unsigned IN_W  = CELL_IN_W,
  parameter int unsigned OUT_W = CELL_OUT_W
) (
  input  logic [IN_W-1:0]  din,
  input  logic [OUT_W-1:0] flip,
  output logic [OUT_W-1:0] dout,
  output logic             par_in,
  output logic             par_out
);
  logic [OUT_W-1:0] raw;

  generate
    if (KIND == CK_SPLIT) begin : g_split
      assign raw = {din[0], ~din[0]};
    end else if (KIND == CK_LOW) begin : g_low
      assign raw = {~din[2] & din[1], ~din[2] & din[0]};
    end else begin : g_high
      assign raw = {din[2] & din[1], din[2] & din[0]};
    end
  endgenerate

  assign dout    = raw ^ flip;
  assign par_in  = ^din;
  assign par_out = ^dout;
endmodule

// File: rtl/pcd_cell.sv
module pcd_cell
  import pcd_pkg::*;
#(
  parameter cell_kind_e KIND = CK_SPLIT,
  parameter int unsigned IN_W  = CELL_IN_W,
  parameter int unsigned OUT_W = CELL_OUT_W
) (
  input  logic [IN_W-1:0]  din,
  input  logic [OUT_W-1:0] flip_a,
  input  logic [OUT_W-1:0] flip_b,
  output logic [OUT_W-1:0] dout,
  output logic             fault
);
  logic [OUT_W-1:0] dout_b;
  logic pin_a, pin_b, pout_a, pout_b;
  logic in_diff, out_diff;

  pcd_copy #(.KIND(KIND), .IN_W(IN_W), .OUT_W(OUT_W)) u_copy_a (
    .din(din), .flip(flip_a), .dout(dout),
    .par_in(pin_a), .par_out(pout_a)
  );

  pcd_copy #(.KIND(KIND), .IN_W(IN_W), .OUT_W(OUT_W)) u_copy_b (
    .din(din), .flip(flip_b), .dout(dout_b),
    .par_in(pin_b), .par_out(pout_b)
  );

  // Flag when input agreement and output agreement disagree.
  assign in_diff  = pin_a ^ pin_b;
  assign out_diff = pout_a ^ pout_b;
  assign fault    = in_diff ^ out_diff;
endmodule

// File: rtl/pcd_chain.sv
module pcd_chain #(
  parameter int unsigned N    = 3,
  parameter logic        SEED = 1'b0
) (
  input  logic [N-1:0] flags,
  output logic         tail
);
  logic [N:0] link;
  assign link[0] = SEED;
  generate
    for (genvar i = 0; i < N; i++) begin : g_link
      assign link[i+1] = link[i] ^ flags[i];
    end
  endgenerate
  assign tail = link[N];
endmodule

// File: rtl/pcd_decoder.sv
module pcd_decoder
  import pcd_pkg::*;
#(
  parameter logic CHAIN_SEED = 1'b0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [INJ_W-1:0] inj_a,
  input  logic [INJ_W-1:0] inj_b,
  output logic [Y_W-1:0]   y,
  output logic             err_t,
  output logic [NCELL-1:0] fault_cell
);
  logic [CELL_OUT_W-1:0] pair;
  logic [CELL_OUT_W-1:0] half_lo, half_hi;

  pcd_cell #(.KIND(CK_SPLIT)) u_cell0 (
    .din({2'b00, sel[0]}),
    .flip_a(inj_a[1:0]), .flip_b(inj_b[1:0]),
    .dout(pair), .fault(fault_cell[0])
  );

  pcd_cell #(.KIND(CK_LOW)) u_cell1 (
    .din({sel[1], pair}),
    .flip_a(inj_a[3:2]), .flip_b(inj_b[3:2]),
    .dout(half_lo), .fault(fault_cell[1])
  );

  pcd_cell #(.KIND(CK_HIGH)) u_cell2 (
    .din({sel[1], pair}),
    .flip_a(inj_a[5:4]), .flip_b(inj_b[5:4]),
    .dout(half_hi), .fault(fault_cell[2])
  );

  assign y = {half_hi, half_lo};

  pcd_chain #(.N(NCELL), .SEED(CHAIN_SEED)) u_chain (
    .flags(fault_cell), .tail(err_t)
  );
endmodule

// File: rtl/pcd_decoder_chk.sv
module pcd_decoder_chk
  import pcd_pkg::*;
(
  input logic [SEL_W-1:0] sel,
  input logic [INJ_W-1:0] inj_a,
  input logic [INJ_W-1:0] inj_b,
  input logic [Y_W-1:0]   y,
  input logic             err_t,
  input logic [NCELL-1:0] fault_cell
);
  always_comb begin
    if (inj_a == '0 && inj_b == '0) begin
      // R1
      decode_onehot_chk: assert (y == (Y_W'(1) << sel));
      // R2
      quiet_flags_chk: assert (err_t == 1'b0 && fault_cell == '0);
    end
    if ($countones({inj_a, inj_b}) == 1) begin
      // R5
      single_flag_chk: assert (err_t == 1'b1 && $countones(fault_cell) == 1);
    end
    if (inj_a == '0 && inj_b != '0) begin
      // R4
      b_isolated_chk: assert (y == (Y_W'(1) << sel));
    end
    if ($countones(fault_cell) == 2) begin
      // R7
      pair_cancel_chk: assert (err_t == 1'b0);
    end
  end
endmodule

bind pcd_decoder pcd_decoder_chk u_pcd_decoder_chk (
  .sel(sel), .inj_a(inj_a), .inj_b(inj_b),
  .y(y), .err_t(err_t), .fault_cell(fault_cell)
);

// File: tb/pcd_decoder_bench.sv
module pcd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = '0;
  logic [5:0] inj_a = '0;
  logic [5:0] inj_b = '0;
  logic [3:0] y;
  logic       err_t;
  logic [2:0] fault_cell;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcd_decoder u_pcd_decoder (
    .sel(sel), .inj_a(inj_a), .inj_b(inj_b),
    .y(y), .err_t(err_t), .fault_cell(fault_cell)
  );

  // Behavioural reference built from the requirement text.
  function automatic logic [3:0] ref_y(input logic [1:0] s, input logic [5:0] ia);
    logic [1:0] pr;
    logic [3:0] r;
    pr = {s[0], ~s[0]} ^ ia[1:0];
    r[0] = ~s[1] & pr[0];
    r[1] = ~s[1] & pr[1];
    r[2] =  s[1] & pr[0];
    r[3] =  s[1] & pr[1];
    r[1:0] = r[1:0] ^ ia[3:2];
    r[3:2] = r[3:2] ^ ia[5:4];
    return r;
  endfunction

  function automatic logic [2:0] ref_fault(input logic [5:0] ia, input logic [5:0] ib);
    logic [2:0] f;
    for (int k = 0; k < 3; k++) begin
      int n;
      n = 0;
      for (int j = 0; j < 2; j++) n += int'(ia[2*k+j]) + int'(ib[2*k+j]);
      f[k] = (n % 2) == 1;
    end
    return f;
  endfunction

  task automatic check(input string req);
    logic [3:0] ey;
    logic [2:0] ef;
    logic       et;
    ey = ref_y(sel, inj_a);
    ef = ref_fault(inj_a, inj_b);
    et = ef[0] ^ ef[1] ^ ef[2];
    checks++;
    if (y !== ey || fault_cell !== ef || err_t !== et) begin
      failures++;
      $display("FAIL %s sel=%0d ia=%b ib=%b: y=%b fault=%b t=%b expected y=%b fault=%b t=%b",
               req, sel, inj_a, inj_b, y, fault_cell, err_t, ey, ef, et);
    end
  endtask

  // Drive on the rising edge, compare on the falling edge.
  task automatic apply(input logic [1:0] s, input logic [5:0] ia, input logic [5:0] ib,
                       input string req);
    @(posedge clk);
    sel = s; inj_a = ia; inj_b = ib;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset-state");
    if (y !== 4'b0001) begin
      failures++;
      $display("FAIL R1 reset y=%b expected 0001", y);
    end
    checks++;

    for (int s = 0; s < 4; s++) apply(2'(s), '0, '0, "R1 R2 clean decode");

    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 6; b++) begin
        apply(2'(s), 6'(1 << b), '0, "R3 R5 single flip copy A");
        apply(2'(s), '0, 6'(1 << b), "R4 R5 single flip copy B");
        checks++;
        if (y !== 4'(1 << s)) begin
          failures++;
          $display("FAIL R4 y=%b expected %b", y, 4'(1 << s));
        end
      end

    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 3; k++) begin
        apply(2'(s), 6'(3 << (2*k)), '0, "R6 two flips same copy");
        apply(2'(s), 6'(1 << (2*k)), 6'(2 << (2*k)), "R6 flips split over copies");
        apply(2'(s), 6'(1 << (2*k)), 6'(1 << (2*k)), "R6 same bit both copies");
      end

    for (int s = 0; s < 4; s++) begin
      apply(2'(s), 6'b000101, '0, "R7 cells 0 and 1");
      apply(2'(s), '0, 6'b100010, "R7 cells 0 and 2");
      apply(2'(s), 6'b010000, 6'b000100, "R7 cells 1 and 2");
      apply(2'(s), 6'b010101, '0, "R7 all three cells");
    end

    apply(2'd3, '0, '0, "R1 R2 back to clean");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule